// File: doc/BRIEF.md
# Indexed Block Register Slave for a Two-Wire Serial Bus

This block lets a host on a two-wire serial bus (SMBus/I2C style, open-drain data line) read and write a bank of byte-wide configuration registers. The bank belongs to the surrounding design. The host always names a starting register index. A write then carries a byte count and that many data bytes, which land in consecutive registers. A read uses a repeated START to turn the bus around. The slave first returns the content of a dedicated count register and then streams registers from the index onward until the host answers with a NACK.

Both bus lines are brought into the system clock domain through synchronizer flops. START and STOP are recognised as data-line edges while the clock line is high. The slave pulls the data line low to acknowledge and to send zero bits. It changes its drive only while the synchronized clock line is low. One register has read-only low bits that always show a status input. The whole bank is presented to the rest of the chip as a flat vector.

Top module: `smb_regbank_slave`

## Requirements
- R1: After reset every register reads 00h except the count register at index 8, which reads 0Fh, and the slave does not pull the data line.
- R2: The slave acknowledges the 8-bit address bytes D2h (write) and D3h (read). Any other address byte is not acknowledged, and the rest of that transfer changes no register.
- R3: A write START, D2h, index N, count X, data bytes, STOP stores the first X data bytes in registers N, N+1, …. Every byte of the sequence is acknowledged.
- R4: Data bytes beyond the count X are acknowledged but not stored. A count of 0 stores nothing.
- R5: A read START, D2h, N, repeated START, D3h returns the count register (index 8) first. It then returns registers N, N+1, … for as long as the host acknowledges. After the host's NACK the slave releases the data line.
- R6: The index pointer advances by one after each stored or returned data byte and wraps from 15 to 0. An index byte is taken modulo 16, its low four bits.
- R7: In register 5, bits [4:0] are read-only and always show ro_status_i[4:0]. A write to register 5 changes only bits [7:5].
- R8: A STOP at any point returns the slave to idle with the data line released. A partly received byte is discarded.
- R9: A START at any point discards a partly received byte and begins reception of a new address byte.
- R10: The slave changes its data-line drive only while the synchronized clock line is low, and it never pulls the line while idle.
- R11: cfg_o shows register i on bits [8i+7:8i], with the read-only bits of R7 merged in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| ro_status_i | input | 8 | Status bits shown in the read-only field of register 5 |
| cfg_o | output | 128 | Flat view of all 16 registers |

## Verification
The bench aims at the edges of the pointer and count logic: a write that runs over the end of the bank, a read that crosses index 15, a zero count and bytes beyond the count. A design with an off-by-one count would store one byte too many or too few. A pointer without a wrap would write outside the bank or return the wrong byte after index 15. Aborts are covered with a STOP inside a data byte and with a repeated START after three bits. A design that commits partial bytes or fails to restart address matching would corrupt a register or miss the acknowledge of D3h. Writes to the read-only field and a change of the status input show whether the merge masks the correct bits.

// File: rtl/smb_pkg.sv
// Shared types for the register slave: bus phase and byte role.
package smb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,   // not addressed, waiting for START
        PH_RX,     // shifting in a byte from the host
        PH_RXACK,  // slave drives the acknowledge bit
        PH_TX,     // shifting out a byte to the host
        PH_TXACK   // host drives the acknowledge bit
    } smb_phase_e;

    typedef enum logic [1:0] {
        SG_ADDR,   // byte being received is the address
        SG_INDEX,  // byte being received is the starting index
        SG_COUNT,  // byte being received is the write count
        SG_WDATA   // byte being received is write data
    } smb_stage_e;
endpackage

// File: rtl/smb_line_sync.sv
// Brings the bus clock and data lines into the system clock domain and
// derives clock edges plus START/STOP conditions.
// Assumes the bus is much slower than clk (several clk cycles per quarter bit).
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchronizer chains plus one history flop per line; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl = sda_pipe[SYNC_STAGES-1];

    // Edge and bus-condition decode from current and previous levels.
    always_comb begin
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/smb_reg_bank.sv
// Byte-wide register bank with one write port, one indexed read port, a
// dedicated count-register tap and a flat view. One register carries a
// read-only field that mirrors a status input.
// Assumes NREG is a power of two.
module smb_reg_bank #(
    parameter int               NREG      = 16,
    parameter int               CNT_INDEX = 8,
    parameter logic [7:0]       CNT_RESET = 8'h0F,
    parameter int               RO_INDEX  = 5,
    parameter logic [7:0]       RO_MASK   = 8'h1F,
    localparam int              IW        = $clog2(NREG),
    localparam int              DW        = smb_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic [IW-1:0]     rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic [DW-1:0]     cnt_value,
    input  logic [DW-1:0]     ro_i,
    output logic [NREG*DW-1:0] flat_o
);
    logic [DW-1:0] store [NREG];
    logic [DW-1:0] view  [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] RST = (g == CNT_INDEX) ? CNT_RESET : '0;
        localparam logic [DW-1:0] MSK = (g == RO_INDEX)  ? RO_MASK   : '0;

        // Holds the writable bits of register g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                store[g] <= RST;
            else if (wr_en && wr_idx == IW'(g))
                store[g] <= wr_data & ~MSK;
        end

        // Read view merges the read-only field from the status input.
        assign view[g] = (store[g] & ~MSK) | (ro_i & MSK);
        assign flat_o[g*DW +: DW] = view[g];
    end

    assign rd_data   = view[rd_idx];
    assign cnt_value = view[CNT_INDEX];
endmodule

// File: rtl/smb_proto_fsm.sv
// Bus protocol engine: address match, index/count/data byte roles,
// acknowledge generation, byte transmission and pointer handling.
// Assumes synchronized edges from smb_line_sync and NREG a power of two.
module smb_proto_fsm
    import smb_pkg::*;
#(
    parameter int         NREG  = 16,
    parameter logic [6:0] ADDR7 = 7'h69,
    localparam int        IW    = $clog2(NREG),
    localparam int        DW    = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic [DW-1:0] rd_data,
    input  logic [DW-1:0] cnt_value,
    output logic          sda_pull,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic [IW-1:0] rd_idx,
    output smb_phase_e    phase_o
);
    smb_phase_e    phase;
    smb_stage_e    stage;
    logic [3:0]    bitcnt;
    logic [DW-1:0] shreg;
    logic          is_read;
    logic          ack_ok;
    logic [IW-1:0] ptr;
    logic [DW-1:0] remain;

    // Next pointer value with wrap at the end of the bank.
    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == IW'(NREG - 1)) ? '0 : p + 1'b1;
    endfunction

    // Commit strobe: a complete data byte while count remains.
    always_comb begin
        wr_en   = (phase == PH_RX) && (stage == SG_WDATA) && (bitcnt == 4'd8)
                  && scl_fall && (remain != '0);
        wr_idx  = ptr;
        wr_data = shreg;
        rd_idx  = ptr;
        phase_o = phase;
    end

    // Protocol sequencing; STOP and START take priority over bit activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            stage    <= SG_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            is_read  <= 1'b0;
            ack_ok   <= 1'b0;
            ptr      <= '0;
            remain   <= '0;
            sda_pull <= 1'b0;
        end else if (stop_evt) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else if (start_evt) begin
            phase    <= PH_RX;
            stage    <= SG_ADDR;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: ;
                PH_RX: begin
                    if (scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[DW-2:0], sda_lvl};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        unique case (stage)
                            SG_ADDR: begin
                                if (shreg[7:1] == ADDR7) begin
                                    is_read  <= shreg[0];
                                    sda_pull <= 1'b1;
                                    phase    <= PH_RXACK;
                                end else begin
                                    phase    <= PH_IDLE;
                                end
                            end
                            SG_INDEX: begin
                                ptr      <= shreg[IW-1:0];
                                sda_pull <= 1'b1;
                                phase    <= PH_RXACK;
                            end
                            SG_COUNT: begin
                                remain   <= shreg;
                                sda_pull <= 1'b1;
                                phase    <= PH_RXACK;
                            end
                            SG_WDATA: begin
                                if (remain != '0) begin
                                    ptr    <= step(ptr);
                                    remain <= remain - 1'b1;
                                end
                                sda_pull <= 1'b1;
                                phase    <= PH_RXACK;
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
                PH_RXACK: begin
                    if (scl_fall) begin
                        if (stage == SG_ADDR && is_read) begin
                            sda_pull <= ~cnt_value[DW-1];
                            shreg    <= {cnt_value[DW-2:0], 1'b0};
                            bitcnt   <= '0;
                            phase    <= PH_TX;
                        end else begin
                            sda_pull <= 1'b0;
                            phase    <= PH_RX;
                            unique case (stage)
                                SG_ADDR:  stage <= SG_INDEX;
                                SG_INDEX: stage <= SG_COUNT;
                                default:  stage <= SG_WDATA;
                            endcase
                        end
                    end
                end
                PH_TX: begin
                    if (scl_rise && bitcnt < 4'd8) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            phase    <= PH_TXACK;
                        end else begin
                            sda_pull <= ~shreg[DW-1];
                            shreg    <= {shreg[DW-2:0], 1'b0};
                        end
                    end
                end
                PH_TXACK: begin
                    if (scl_rise) begin
                        ack_ok <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (ack_ok) begin
                            sda_pull <= ~rd_data[DW-1];
                            shreg    <= {rd_data[DW-2:0], 1'b0};
                            ptr      <= step(ptr);
                            phase    <= PH_TX;
                        end else begin
                            phase    <= PH_IDLE;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smb_regbank_slave.sv
// Top level: line synchronizers, protocol engine and register bank.
// Assumes an external pull-up on the data line; sda_pull_o enables the
// open-drain low drive.
module smb_regbank_slave
    import smb_pkg::*;
#(
    parameter int         NREG        = 16,
    parameter logic [6:0] ADDR7       = 7'h69,
    parameter int         CNT_INDEX   = 8,
    parameter logic [7:0] CNT_RESET   = 8'h0F,
    parameter int         RO_INDEX    = 5,
    parameter logic [7:0] RO_MASK     = 8'h1F,
    parameter int         SYNC_STAGES = 2,
    localparam int        IW          = $clog2(NREG),
    localparam int        DW          = BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [DW-1:0]      ro_status_i,
    output logic [NREG*DW-1:0] cfg_o
);
    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic          wr_en;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [DW-1:0] wr_data, rd_data, cnt_value;
    smb_phase_e    phase;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
    );

    smb_proto_fsm #(.NREG(NREG), .ADDR7(ADDR7)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .rd_data(rd_data), .cnt_value(cnt_value), .sda_pull(sda_pull_o),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .phase_o(phase)
    );

    smb_reg_bank #(
        .NREG(NREG), .CNT_INDEX(CNT_INDEX), .CNT_RESET(CNT_RESET),
        .RO_INDEX(RO_INDEX), .RO_MASK(RO_MASK)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .cnt_value(cnt_value), .ro_i(ro_status_i), .flat_o(cfg_o)
    );
endmodule

// File: rtl/smb_regbank_slave_chk.sv
// Protocol checker bound to the top: data-line drive discipline around
// bus clock level and START/STOP conditions.
module smb_regbank_slave_chk
    import smb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       sda_pull_o,
    input smb_phase_e phase
);
    // R10
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_lvl);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_pull_o);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_pull_o && phase == PH_IDLE));

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (!sda_pull_o && phase == PH_RX));
endmodule

bind smb_regbank_slave smb_regbank_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_evt(start_evt),
    .stop_evt(stop_evt), .sda_pull_o(sda_pull_o), .phase(phase)
);

// File: tb/smb_regbank_slave_tb.sv
// Bench: bus master tasks, a behavioural register model and a per-cycle
// comparison of the flat register view whenever the bus is idle.
module smb_regbank_slave_tb;
    localparam int Q = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         sda_pull_o;
    logic [7:0]   ro_val = 8'h0A;
    logic [127:0] cfg_o;
    wire          sda_bus = m_sda & ~sda_pull_o;

    int  checks = 0;
    int  fails = 0;
    bit  cmp_en = 1'b0;
    bit  done = 1'b0;
    logic [7:0] mreg [16];

    always #2 clk = ~clk;

    smb_regbank_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull_o), .ro_status_i(ro_val), .cfg_o(cfg_o)
    );

    function automatic logic [7:0] mview(int i);
        if (i == 5) return (mreg[5] & 8'hE0) | (ro_val & 8'h1F);
        return mreg[i];
    endfunction

    function automatic logic [127:0] mflat();
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = mview(i);
        return v;
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R11 / R1: whole-bank comparison every idle cycle
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(cfg_o === mflat(), "R11 flat view", cfg_o, mflat());
            chk(sda_pull_o === 1'b0, "R10 idle release", sda_pull_o, 0);
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq();
            m_scl = 1'b0;
        end
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = (sda_bus == 1'b0);
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = sda_bus;
            m_scl = 1'b0;
        end
        wq();
        m_sda = ~ack; wq();
        m_scl = 1'b1; wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
        cmp_en = 1'b1;
    endtask

    task automatic blk_write(input int idx, input int cnt, input logic [7:0] d[$]);
        bit a;
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hD2, a);       chk(a, "R2 write address ack", a, 1);
        send_byte(8'(idx), a);     chk(a, "R3 index ack", a, 1);
        send_byte(8'(cnt), a);     chk(a, "R3 count ack", a, 1);
        foreach (d[k]) begin
            send_byte(d[k], a);
            chk(a, (k < cnt) ? "R3 data ack" : "R4 extra byte ack", a, 1);
        end
        bus_stop();
        for (int k = 0; k < d.size() && k < cnt; k++) begin
            int j = (idx + k) % 16;
            mreg[j] = (j == 5) ? (d[k] & 8'hE0) : d[k];
        end
        settle();
    endtask

    task automatic blk_read(input int idx, input int n, input string req);
        bit a;
        logic [7:0] b;
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hD2, a);   chk(a, "R2 write address ack", a, 1);
        send_byte(8'(idx), a); chk(a, "R5 index ack", a, 1);
        bus_rstart();
        send_byte(8'hD3, a);   chk(a, "R2 read address ack", a, 1);
        recv_byte(b, 1'b1);    chk(b === mview(8), "R5 count byte first", b, mview(8));
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k < n - 1);
            chk(b === mview((idx + k) % 16), req, b, mview((idx + k) % 16));
        end
        repeat (4) @(negedge clk);
        chk(sda_pull_o === 1'b0, "R5 release after NACK", sda_pull_o, 0);
        bus_stop();
        settle();
    endtask

    initial begin
        bit a;
        logic [7:0] b;
        foreach (mreg[i]) mreg[i] = 8'h00;
        mreg[8] = 8'h0F;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_o === mflat(), "R1 reset values", cfg_o, mflat());
        chk(cfg_o[71:64] === 8'h0F, "R1 count register reset", cfg_o[71:64], 8'h0F);
        chk(sda_pull_o === 1'b0, "R1 line released", sda_pull_o, 0);
        settle();

        // R3 basic block write and read back
        blk_write(2, 3, '{8'hA1, 8'hB2, 8'hC3});
        blk_read(2, 3, "R3 stored data");

        // R2 foreign address: NACK, nothing stored
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hA4, a); chk(!a, "R2 foreign address nack", a, 0);
        send_byte(8'h02, a); chk(!a, "R2 no ack after mismatch", a, 0);
        send_byte(8'h01, a);
        send_byte(8'h55, a);
        bus_stop();
        settle();
        blk_read(2, 1, "R2 register untouched");

        // R6 wrap across the end of the bank
        blk_write(15, 3, '{8'h11, 8'h22, 8'h33});
        blk_read(14, 4, "R6 read wraps");
        blk_write(8'h13, 1, '{8'h5C});
        blk_read(3, 1, "R6 index modulo bank size");

        // R7 read-only field
        blk_write(5, 1, '{8'hFF});
        chk(cfg_o[47:40] === 8'hEA, "R7 read-only merge", cfg_o[47:40], 8'hEA);
        ro_val = 8'h15;
        @(negedge clk);
        chk(cfg_o[47:40] === 8'hF5, "R7 tracks status input", cfg_o[47:40], 8'hF5);
        blk_read(5, 1, "R7 read-only via bus");

        // R4 extra bytes and zero count
        blk_write(10, 1, '{8'h9E, 8'h6D});
        chk(cfg_o[95:88] === 8'h00, "R4 byte past count not stored", cfg_o[95:88], 0);
        blk_write(12, 0, '{8'h77});
        chk(cfg_o[103:96] === 8'h00, "R4 zero count stores nothing", cfg_o[103:96], 0);

        // R5 count register sets the first returned byte
        blk_write(8, 1, '{8'h04});
        blk_read(0, 2, "R5 data after count");

        // R8 STOP inside a data byte
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h03, a); send_byte(8'h01, a);
        send_bits(8'h5A, 4);
        bus_stop();
        repeat (4) @(negedge clk);
        chk(sda_pull_o === 1'b0, "R8 released after stop", sda_pull_o, 0);
        settle();
        chk(cfg_o[31:24] === 8'h5C, "R8 partial byte discarded", cfg_o[31:24], 8'h5C);

        // R9 repeated START inside a data byte, then a read
        cmp_en = 1'b0;
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h04, a); send_byte(8'h01, a);
        send_bits(8'hC3, 3);
        bus_rstart();
        send_byte(8'hD3, a); chk(a, "R9 address after restart", a, 1);
        recv_byte(b, 1'b1);  chk(b === mview(8), "R9 count after restart", b, mview(8));
        recv_byte(b, 1'b0);  chk(b === mview(4), "R9 register untouched", b, mview(4));
        bus_stop();
        settle();

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule